// File: doc/BRIEF.md
# Processor status flag update unit

This block holds the 8-bit processor status register of a CPU core with two operating modes: a native mode and a narrow compatibility (emulation) mode. On each clock the block takes one flag operation. The operations are set-bits, clear-bits, load-from-stack and return-from-interrupt load. The block also works out how wide the index registers are. One status bit, the index-select bit, sets the width of both index registers together. The register file reads the width output. When the width narrows, a single-cycle truncate pulse tells the register file to clear the upper bytes of both index registers.

While the emulation input is high, the index-select position is treated as a break flag. The block holds that bit at 1, so the index width stays 8 bits whatever operand is applied. The bit can therefore be 0 only in native mode. Instruction decode, the stack access and the register file itself sit outside this block.

All pins are plain control and status signals. The block has no streaming interface and applies no back-pressure. An operation presented before a rising edge takes effect at that edge, so every output reflects it one clock later.

Top module: `psr_flag_unit`

## Requirements
- R1: While reset (rst_n low, asynchronous) is applied and after it ends, the status byte is 0x34, emulation is in effect, idx_wide is 0 and idx_trunc is 0.
- R2: op_sel = 1 (set-bits) sets every status bit whose op_data bit is 1 and leaves the other bits unchanged, visible one clock later.
- R3: op_sel = 2 (clear-bits) in native mode clears every status bit whose op_data bit is 1, bit 4 included, and leaves the other bits unchanged.
- R4: op_sel = 3 (load-from-stack) and op_sel = 4 (return-from-interrupt) in native mode replace the whole status byte with op_data, bit 4 included.
- R5: op_sel = 0, and the unused codes 5 to 7, leave the status byte unchanged in native mode.
- R6: idx_wide is 1 (16-bit index registers) exactly when status bit 4 is 0 and the registered mode is native. Otherwise it is 0 (8-bit). This one output governs both index registers.
- R7: With emu_mode high at a clock edge, status bit 4 is 1 after that edge for every operation. A clear-bits operation with bit 4 set therefore leaves the index width at 8 bits.
- R8: idx_trunc is high for exactly one cycle after each clock edge at which idx_wide goes from 1 to 0, and is 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_sel | input | 3 | Operation: 0 none, 1 set-bits, 2 clear-bits, 3 stack load, 4 interrupt-return load, 5-7 none |
| op_data | input | 8 | Operand mask or popped status byte |
| emu_mode | input | 1 | 1 = emulation mode, 0 = native mode |
| status_q | output | 8 | Visible status byte |
| idx_wide | output | 1 | 1 = index registers 16 bits, 0 = 8 bits |
| idx_trunc | output | 1 | One-cycle pulse when the index width narrows |

## Verification
A wrong bit in the status register shows on status_q one clock after the operation that caused it. If the fault is in bit 4, idx_wide is wrong in that same cycle. A missed or extra truncate pulse is visible only in the single cycle after the width changes, so idx_trunc is sampled after every edge. Cases where emulation mode hides a cleared index bit show up one clock after the return to native mode, when idx_wide would wrongly rise.

// File: rtl/psr_pkg.sv
package psr_pkg;
  typedef enum logic [2:0] {
    PSR_OP_NONE = 3'd0,
    PSR_OP_SET  = 3'd1,
    PSR_OP_CLR  = 3'd2,
    PSR_OP_PULL = 3'd3,
    PSR_OP_RTI  = 3'd4
  } psr_op_e;
endpackage

// File: rtl/psr_next.sv
module psr_next
  import psr_pkg::*;
#(
  parameter int W       = 8,
  parameter int IDX_BIT = 4
) (
  input  logic [W-1:0] cur,
  input  logic [2:0]   op_sel,
  input  logic [W-1:0] op_data,
  input  logic         emu_mode,
  output logic [W-1:0] nxt
);
  psr_op_e op;
  assign op = psr_op_e'(op_sel);

  for (genvar b = 0; b < W; b++) begin : g_bit
    localparam bit IS_IDX = (b == IDX_BIT);
    logic upd;
    always_comb begin
      case (op)
        PSR_OP_SET:              upd = cur[b] | op_data[b];
        PSR_OP_CLR:              upd = cur[b] & ~op_data[b];
        PSR_OP_PULL, PSR_OP_RTI: upd = op_data[b];
        default:                 upd = cur[b];
      endcase
    end
    if (IS_IDX) begin : g_idx
      // break-flag position is pinned high while in emulation
      assign nxt[b] = upd | emu_mode;
    end else begin : g_plain
      assign nxt[b] = upd;
    end
  end
endmodule

// File: rtl/psr_width.sv
module psr_width (
  input  logic clk,
  input  logic rst_n,
  input  logic idx_bit_q,
  input  logic emu_q,
  output logic idx_wide,
  output logic idx_trunc
);
  logic wide_prev_q;

  assign idx_wide  = ~idx_bit_q & ~emu_q;
  assign idx_trunc = wide_prev_q & ~idx_wide;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wide_prev_q <= 1'b0;
    else        wide_prev_q <= idx_wide;
  end

  assert_trunc_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idx_trunc |=> !idx_trunc);
  assert_trunc_narrow_R8: assert property (@(posedge clk) disable iff (!rst_n)
    idx_trunc |-> !idx_wide);
  assert_trunc_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idx_wide) |-> idx_trunc);
endmodule

// File: rtl/psr_flag_unit.sv
module psr_flag_unit
  import psr_pkg::*;
#(
  parameter int            W         = 8,
  parameter int            IDX_BIT   = 4,
  parameter logic [W-1:0]  RESET_VAL = 8'h34
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [2:0]   op_sel,
  input  logic [W-1:0] op_data,
  input  logic         emu_mode,
  output logic [W-1:0] status_q,
  output logic         idx_wide,
  output logic         idx_trunc
);
  logic [W-1:0] status_d;
  logic         emu_q;

  psr_next #(.W(W), .IDX_BIT(IDX_BIT)) u_next (
    .cur      (status_q),
    .op_sel   (op_sel),
    .op_data  (op_data),
    .emu_mode (emu_mode),
    .nxt      (status_d)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= RESET_VAL;
      emu_q    <= 1'b1;
    end else begin
      status_q <= status_d;
      emu_q    <= emu_mode;
    end
  end

  psr_width u_width (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx_bit_q (status_q[IDX_BIT]),
    .emu_q     (emu_q),
    .idx_wide  (idx_wide),
    .idx_trunc (idx_trunc)
  );

  assert_set_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == PSR_OP_SET) |=> ((status_q & $past(op_data)) == $past(op_data)));
  assert_clr_bits_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == PSR_OP_CLR && !emu_mode) |=> ((status_q & $past(op_data)) == '0));
  assert_load_byte_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ((op_sel == PSR_OP_PULL || op_sel == PSR_OP_RTI) && !emu_mode)
      |=> (status_q == $past(op_data)));
  assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == PSR_OP_NONE && !emu_mode) |=> $stable(status_q));
  assert_emu_forces_R7: assert property (@(posedge clk) disable iff (!rst_n)
    emu_mode |=> (status_q[IDX_BIT] && !idx_wide));
  assert_wide_native_R6: assert property (@(posedge clk) disable iff (!rst_n)
    idx_wide |-> (!emu_q && !status_q[IDX_BIT]));
endmodule

// File: tb/psr_flag_unit_tb.sv
module psr_flag_unit_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] op_sel = 3'd0;
  logic [7:0] op_data = 8'h00;
  logic       emu_mode = 1'b1;
  logic [7:0] status_q;
  logic       idx_wide, idx_trunc;

  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  psr_flag_unit u_dut (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .op_data(op_data),
    .emu_mode(emu_mode), .status_q(status_q), .idx_wide(idx_wide),
    .idx_trunc(idx_trunc)
  );

  // {emu, op, data, exp_status, exp_wide, exp_trunc}
  localparam logic [21:0] VEC [NVEC] = '{
    {1'b1, 3'd2, 8'h10, 8'h34, 1'b0, 1'b0},  // R7 clear in emulation
    {1'b0, 3'd0, 8'h00, 8'h34, 1'b0, 1'b0},  // R5
    {1'b0, 3'd2, 8'h30, 8'h04, 1'b1, 1'b0},  // R3 R6
    {1'b0, 3'd1, 8'h01, 8'h05, 1'b1, 1'b0},  // R2
    {1'b0, 3'd1, 8'h10, 8'h15, 1'b0, 1'b1},  // R2 R8
    {1'b0, 3'd0, 8'hFF, 8'h15, 1'b0, 1'b0},  // R5 R8
    {1'b0, 3'd3, 8'h82, 8'h82, 1'b1, 1'b0},  // R4
    {1'b0, 3'd4, 8'hD3, 8'hD3, 1'b0, 1'b1},  // R4 R8
    {1'b0, 3'd2, 8'hFF, 8'h00, 1'b1, 1'b0},  // R3
    {1'b1, 3'd0, 8'h00, 8'h10, 1'b0, 1'b1},  // R7 R8
    {1'b1, 3'd3, 8'h00, 8'h10, 1'b0, 1'b0},  // R7
    {1'b1, 3'd1, 8'hC0, 8'hD0, 1'b0, 1'b0},  // R2 R7
    {1'b0, 3'd3, 8'h00, 8'h00, 1'b1, 1'b0},  // R4 R6
    {1'b0, 3'd1, 8'h00, 8'h00, 1'b1, 1'b0},  // R2 zero mask
    {1'b0, 3'd2, 8'h00, 8'h00, 1'b1, 1'b0},  // R3 zero mask
    {1'b0, 3'd7, 8'hFF, 8'h00, 1'b1, 1'b0}   // R5 unused code
  };

  task automatic check(input string req, input logic [7:0] st,
                       input logic wd, input logic tr);
    n_cmp++;
    if (status_q !== st || idx_wide !== wd || idx_trunc !== tr) begin
      n_bad++;
      $display("FAIL %s: status=%h wide=%b trunc=%b expected status=%h wide=%b trunc=%b",
               req, status_q, idx_wide, idx_trunc, st, wd, tr);
    end
  endtask

  task automatic step(input logic e, input logic [2:0] o, input logic [7:0] d);
    @(negedge clk);
    emu_mode = e; op_sel = o; op_data = d;
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 in reset", 8'h34, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 after reset", 8'h34, 1'b0, 1'b0);

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][21], VEC[i][20:18], VEC[i][17:10]);
      check($sformatf("vector %0d (R2..R8)", i), VEC[i][9:2], VEC[i][1], VEC[i][0]);
    end

    // R1: reset while wide and native returns to narrow without a pulse
    @(negedge clk);
    emu_mode = 1'b0; op_sel = 3'd0;
    rst_n = 1'b0;
    #1;
    check("R1 mid-run reset", 8'h34, 1'b0, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, 3'd0, 8'h00);
    check("R6 native, bit4 set", 8'h34, 1'b0, 1'b0);
    step(1'b0, 3'd2, 8'h10);
    check("R3 clear bit4 widens", 8'h24, 1'b1, 1'b0);
    step(1'b1, 3'd2, 8'h10);
    check("R7 emulation entry forces bit4", 8'h34, 1'b0, 1'b1);
    step(1'b1, 3'd0, 8'h00);
    check("R8 pulse ends", 8'h34, 1'b0, 1'b0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule